// File: doc/BRIEF.md
# Aliasing Program Counter with Fixed Vectors

This block keeps the 13-bit instruction address of a small processor core. The logical counter spans 8K words. The instruction memory behind it is smaller, holding 512, 1024 or 2048 words, and the size is chosen by a parameter. The block forms the physical fetch address by masking the logical value to the implemented size. An address past the end of the memory therefore lands on the matching word near the bottom.

The counter advances by one on each increment strobe. A branch strobe loads a 13-bit target instead. An interrupt-entry request forces the interrupt vector 0004h, and the asynchronous reset forces 0000h. When requests arrive in the same cycle, reset wins, then interrupt entry, then branch, then increment. The return stack, the memory and the interrupt controller sit outside this block.

Top module: `pc_wrap_counter`

## Requirements
- R1: While rst_ni is low, pc_o and fetch_addr_o are 0000h, whatever the strobes are doing.
- R2: With inc_i high and no load_i or irq_i, pc_o increases by one at the next rising clk_i edge. With no strobe high, pc_o holds.
- R3: Incrementing from 1FFFh gives 0000h.
- R4: With load_i high and irq_i low, pc_o takes load_addr_i (all 13 bits) at the next edge.
- R5: With irq_i high, pc_o becomes 0004h at the next edge.
- R6: fetch_addr_o equals pc_o AND (MEM_WORDS-1), with bits at and above log2(MEM_WORDS) at zero. With the default of 2048 words, for example, 0805h maps to 0005h.
- R7: irq_i in the same cycle as load_i and inc_i yields 0004h. The branch target and the increment are discarded.
- R8: load_i in the same cycle as inc_i yields load_addr_i, not load_addr_i+1 and not pc_o+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one active edge per instruction cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Advance strobe |
| load_i | input | 1 | Branch strobe |
| load_addr_i | input | 13 | Branch target (logical) |
| irq_i | input | 1 | Interrupt-entry request |
| pc_o | output | 13 | Logical counter value |
| fetch_addr_o | output | 13 | Physical fetch address, upper bits masked to zero |

## Verification
The contested cycles are those where the interrupt vector, the branch target and the increment all request the same register. The bench raises irq_i together with load_i and inc_i, and separately raises load_i with inc_i. Each time it starts from a counter value whose increment differs from both the target and the vector, so the value after the edge shows exactly which source won. A reset pulse is also applied while all three strobes are held high, and pc_o must stay at zero for the whole pulse.

// File: rtl/pc_wrap_pkg.sv
package pc_wrap_pkg;
  localparam int PC_W = 13;
  typedef logic [PC_W-1:0] pc_t;

  localparam pc_t RST_VEC = 13'h0000;
  localparam pc_t IRQ_VEC = 13'h0004;

  typedef enum logic [1:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_LOAD,
    SEL_IRQ
  } pc_sel_e;
endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_wrap_pkg::*;
(
  input  logic inc_i,
  input  logic load_i,
  input  logic irq_i,
  input  pc_t  cur_i,
  input  pc_t  target_i,
  output pc_t  next_o
);
  pc_sel_e sel;

  // interrupt > branch > increment
  always_comb begin
    if (irq_i)       sel = SEL_IRQ;
    else if (load_i) sel = SEL_LOAD;
    else if (inc_i)  sel = SEL_INC;
    else             sel = SEL_HOLD;
  end

  always_comb begin
    unique case (sel)
      SEL_IRQ:  next_o = IRQ_VEC;
      SEL_LOAD: next_o = target_i;
      SEL_INC:  next_o = cur_i + pc_t'(1);  // natural 13-bit rollover
      default:  next_o = cur_i;
    endcase
  end
endmodule

// File: rtl/pc_alias_mask.sv
module pc_alias_mask
  import pc_wrap_pkg::*;
#(
  parameter int MEM_WORDS = 2048
) (
  input  pc_t pc_i,
  output pc_t phys_o
);
  localparam int AW = $clog2(MEM_WORDS);

  for (genvar b = 0; b < PC_W; b++) begin : g_bit
    if (b < AW) begin : g_keep
      assign phys_o[b] = pc_i[b];
    end else begin : g_drop
      assign phys_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/pc_wrap_counter.sv
module pc_wrap_counter
  import pc_wrap_pkg::*;
#(
  parameter int MEM_WORDS = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        inc_i,
  input  logic        load_i,
  input  logic [12:0] load_addr_i,
  input  logic        irq_i,
  output logic [12:0] pc_o,
  output logic [12:0] fetch_addr_o
);
  pc_t pc_q, pc_d;

  pc_next_sel u_sel (
    .inc_i    (inc_i),
    .load_i   (load_i),
    .irq_i    (irq_i),
    .cur_i    (pc_q),
    .target_i (load_addr_i),
    .next_o   (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RST_VEC;
    else         pc_q <= pc_d;
  end

  pc_alias_mask #(.MEM_WORDS(MEM_WORDS)) u_mask (
    .pc_i   (pc_q),
    .phys_o (fetch_addr_o)
  );

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_wrap_counter_chk.sv
module pc_wrap_counter_chk #(
  parameter int MEM_WORDS = 2048
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        inc_i,
  input logic        load_i,
  input logic [12:0] load_addr_i,
  input logic        irq_i,
  input logic [12:0] pc_o,
  input logic [12:0] fetch_addr_o
);
  localparam logic [12:0] MASK = 13'(MEM_WORDS - 1);

  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && !irq_i) |=> (pc_o == 13'($past(pc_o) + 13'd1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i && !irq_i) |=> $stable(pc_o));

  // R4
  branch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !irq_i) |=> (pc_o == $past(load_addr_i)));

  // R5
  irq_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> (pc_o == 13'h0004));

  // R6
  alias_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o == (pc_o & MASK));
endmodule

bind pc_wrap_counter pc_wrap_counter_chk #(.MEM_WORDS(MEM_WORDS)) u_chk (.*);

// File: tb/tb_pc_wrap_counter.sv
`timescale 1ns/1ps
module tb_pc_wrap_counter;
  localparam int MEM_WORDS = 2048;
  localparam logic [12:0] MASK = 13'(MEM_WORDS - 1);

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inc_i = 1'b0;
  logic        load_i = 1'b0;
  logic [12:0] load_addr_i = '0;
  logic        irq_i = 1'b0;
  logic [12:0] pc_o, fetch_addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pc_wrap_counter #(.MEM_WORDS(MEM_WORDS)) dut (.*);

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive strobes, take one edge, sample 1 ns later, clear strobes
  task automatic cycle(input logic inc, input logic ld, input logic [12:0] tgt, input logic irq);
    inc_i = inc; load_i = ld; load_addr_i = tgt; irq_i = irq;
    @(posedge clk_i); #1;
    inc_i = 0; load_i = 0; irq_i = 0;
  endtask

  task automatic t_reset();
    rst_ni = 0; inc_i = 1; load_i = 1; load_addr_i = 13'h1234; irq_i = 1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 pc under reset", pc_o, 13'h0000);
    chk("R1 fetch under reset", fetch_addr_o, 13'h0000);
    inc_i = 0; load_i = 0; irq_i = 0;
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;
    chk("R1 pc after release", pc_o, 13'h0000);
  endtask

  task automatic t_inc();
    for (int i = 1; i <= 5; i++) begin
      cycle(1, 0, '0, 0);
      chk("R2 increment", pc_o, 13'(i));
    end
    cycle(0, 0, '0, 0);
    chk("R2 hold", pc_o, 13'h0005);
  endtask

  task automatic t_roll();
    cycle(0, 1, 13'h1FFE, 0);
    chk("R4 load 1FFE", pc_o, 13'h1FFE);
    cycle(1, 0, '0, 0);
    chk("R2 to 1FFF", pc_o, 13'h1FFF);
    cycle(1, 0, '0, 0);
    chk("R3 rollover", pc_o, 13'h0000);
  endtask

  task automatic t_load_alias();
    logic [12:0] tg [4] = '{13'h0805, 13'h07FF, 13'h1ABC, 13'h0123};
    for (int i = 0; i < 4; i++) begin
      cycle(0, 1, tg[i], 0);
      chk("R4 branch target", pc_o, tg[i]);
      chk("R6 fetch alias", fetch_addr_o, tg[i] & MASK);
    end
    cycle(1, 0, '0, 0);
    chk("R6 after inc 0124", fetch_addr_o, 13'h0124);
  endtask

  task automatic t_irq();
    cycle(0, 1, 13'h0ABC, 0);
    cycle(0, 0, '0, 1);
    chk("R5 irq vector", pc_o, 13'h0004);
    chk("R6 irq fetch", fetch_addr_o, 13'h0004);
  endtask

  task automatic t_priority();
    cycle(0, 1, 13'h0100, 0);
    cycle(1, 1, 13'h0200, 1);
    chk("R7 irq beats load+inc", pc_o, 13'h0004);
    cycle(0, 1, 13'h0100, 0);
    cycle(1, 1, 13'h0300, 0);
    chk("R8 load beats inc", pc_o, 13'h0300);
    cycle(1, 0, '0, 1);
    chk("R7 irq beats inc", pc_o, 13'h0004);
  endtask

  task automatic t_reset_mid();
    cycle(0, 1, 13'h1555, 0);
    @(negedge clk_i);
    rst_ni = 0; #0.5;
    chk("R1 async clear", pc_o, 13'h0000);
    inc_i = 1; load_i = 1; load_addr_i = 13'h0777; irq_i = 1;
    @(posedge clk_i); #1;
    chk("R1 reset beats strobes", pc_o, 13'h0000);
    inc_i = 0; load_i = 0; irq_i = 0;
    @(negedge clk_i); rst_ni = 1;
    cycle(1, 0, '0, 0);
    chk("R2 inc after reset", pc_o, 13'h0001);
  endtask

  initial begin
    t_reset();
    t_inc();
    t_roll();
    t_load_alias();
    t_irq();
    t_priority();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule